// File: doc/BRIEF.md
# ADC Result Accumulator and Decimator

This block post-processes the raw 12-bit results of a successive-approximation converter core before they reach a 16-bit result register. Each accepted sample either passes straight through at a native resolution of 12, 10 or 8 bits, or is summed into a wide accumulator together with a power-of-two number of neighbours. The finished sum is then scaled down by a right shift.

Two families of accumulating modes exist. In the custom averaging mode, the sample count (1 to 1024) and the shift (0 to 7) are chosen independently. The result may exceed 16 bits, in which case it saturates. In the four oversampling modes, the count and the shift are fixed by the number of extra bits n (1 to 4): 4^n samples are summed and the sum is shifted right by n. This gives 13 to 16 significant bits.

Each finished result is announced by a one-cycle strobe and stays on the result port until the next one. A pending flag remains set until a read acknowledge arrives. If a new result replaces one that has not been acknowledged, a sticky overrun flag is raised. A flush input discards a partly built sum. The converter core, its clock divider and the register bus all lie outside this block. Samples arrive as a plain valid/data stream, and the configuration inputs are expected to stay stable while a window is being collected.

Top module: `adc_accum_decim`

## Requirements
- R1: With mode_i = 0 (12-bit native), every accepted sample produces a result equal to the sample, zero-extended to 16 bits.
- R2: With mode_i = 1 (10-bit native), the result is sample >> 2. With mode_i = 2 (8-bit native), the result is sample >> 4. Each sample gives one result.
- R3: With mode_i = 3 (custom averaging), 2^count_sel_i consecutive samples are summed and the result is sum >> shift_sel_i. count_sel_i values above 10 act as 10, and shift_sel_i is 0 to 7.
- R4: A shifted sum above 65535 is reported as 65535. A shifted sum of 65535 or less is reported exactly.
- R5: With mode_i = 4, 5, 6 or 7 (13, 14, 15 or 16 bits), n = mode_i − 3, 4^n samples are summed and the result is sum >> n. count_sel_i and shift_sel_i are ignored in these modes.
- R6: result_ready_o is high only in the cycle after the clock edge that captured the final sample of a window, so it gives exactly one pulse per window. result_o holds its value until the next result.
- R7: flush_i clears the partial sum and the sample count. A sample that is valid in the same cycle as flush_i is discarded, and no result is produced in that cycle.
- R8: pending_o is set by each new result and cleared by read_ack_i. If a result and read_ack_i arrive in the same cycle, pending_o stays set.
- R9: overrun_o is set when a new result arrives while pending_o is high and read_ack_i is low. Once set, it stays high until read_ack_i clears it.
- R10: After reset, result_o is 0 and result_ready_o, pending_o and overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 12 | Raw conversion result |
| mode_i | input | 3 | 0/1/2 native 12/10/8 bit, 3 custom averaging, 4..7 oversampled 13..16 bit |
| count_sel_i | input | 4 | log2 of the sample count in custom mode |
| shift_sel_i | input | 3 | Right shift applied after accumulation in custom mode |
| flush_i | input | 1 | Discard the partial window |
| read_ack_i | input | 1 | Result consumed, clears the pending flag |
| result_o | output | 16 | Scaled, saturated result |
| result_ready_o | output | 1 | One-cycle new-result strobe |
| pending_o | output | 1 | Result not yet acknowledged |
| overrun_o | output | 1 | Unacknowledged result was replaced |

## Verification
The bench builds the block with its defaults: 12-bit samples, a 16-bit result and a maximum window of 2^10 samples. These values make the widest window reachable, a full-scale 1024-sample sum that must saturate, and the count select clamping above 10. They also cover both sides of the saturation edge: sixteen full-scale samples land exactly at 0xFFF0, while thirty-two exceed the limit. Every oversampling mode runs with its fixed window, including the 256-sample 16-bit case, which reaches 0xFFF0 without clipping.

// File: rtl/adc_ad_pkg.sv
package adc_ad_pkg;
  typedef enum logic [2:0] {
    MODE_RAW12 = 3'd0,
    MODE_RAW10 = 3'd1,
    MODE_RAW8  = 3'd2,
    MODE_AVG   = 3'd3,
    MODE_OS13  = 3'd4,
    MODE_OS14  = 3'd5,
    MODE_OS15  = 3'd6,
    MODE_OS16  = 3'd7
  } adc_mode_e;

  localparam int unsigned OS_BASE = 3;
endpackage

// File: rtl/adc_ad_cfg.sv
module adc_ad_cfg #(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned MAX_LOG2  = 10,
  parameter int unsigned CSEL_W    = 4,
  parameter int unsigned SH_W      = 3,
  localparam int unsigned L2_W     = $clog2(MAX_LOG2 + 1)
) (
  input  logic [2:0]        mode_i,
  input  logic [CSEL_W-1:0] count_sel_i,
  input  logic [SH_W-1:0]   shift_sel_i,
  output logic [L2_W-1:0]   log2_n_o,
  output logic [SH_W-1:0]   shift_o
);
  import adc_ad_pkg::*;

  localparam int unsigned RAW_DROP10 = SAMPLE_W - 10;
  localparam int unsigned RAW_DROP8  = SAMPLE_W - 8;

  adc_mode_e mode;
  logic [CSEL_W-1:0] csel_clamped;

  assign mode = adc_mode_e'(mode_i);
  assign csel_clamped = (count_sel_i > CSEL_W'(MAX_LOG2)) ? CSEL_W'(MAX_LOG2) : count_sel_i;

  always_comb begin
    log2_n_o = '0;
    shift_o  = '0;
    unique case (mode)
      MODE_RAW12: ;
      MODE_RAW10: shift_o = SH_W'(RAW_DROP10);
      MODE_RAW8:  shift_o = SH_W'(RAW_DROP8);
      MODE_AVG: begin
        log2_n_o = L2_W'(csel_clamped);
        shift_o  = shift_sel_i;
      end
      default: begin
        // n extra bits: 4^n samples, shift by n
        log2_n_o = L2_W'(2 * (int'(mode_i) - int'(OS_BASE)));
        shift_o  = SH_W'(int'(mode_i) - int'(OS_BASE));
      end
    endcase
  end
endmodule

// File: rtl/adc_ad_accum.sv
module adc_ad_accum #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned MAX_LOG2 = 10,
  localparam int unsigned ACC_W   = SAMPLE_W + MAX_LOG2,
  localparam int unsigned CNT_W   = (MAX_LOG2 > 0) ? MAX_LOG2 : 1,
  localparam int unsigned L2_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                flush_i,
  input  logic [L2_W-1:0]     log2_n_i,
  output logic                emit_o,
  output logic [ACC_W-1:0]    sum_o
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   target;
  logic             take;

  assign target = ((CNT_W+1)'(1) << log2_n_i) - (CNT_W+1)'(1);
  assign take   = valid_i && !flush_i;
  assign sum_o  = acc_q + ACC_W'(sample_i);
  assign emit_o = take && (cnt_q == target[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (flush_i || emit_o) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= sum_o;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_ad_scale.sv
module adc_ad_scale #(
  parameter int unsigned ACC_W    = 22,
  parameter int unsigned RESULT_W = 16,
  parameter int unsigned SH_W     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                emit_i,
  input  logic [ACC_W-1:0]    sum_i,
  input  logic [SH_W-1:0]     shift_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                ready_o
);
  logic [ACC_W-1:0]    shifted;
  logic [RESULT_W-1:0] clipped;

  assign shifted = sum_i >> shift_i;

  generate
    if (ACC_W > RESULT_W) begin : g_sat
      assign clipped = (|shifted[ACC_W-1:RESULT_W]) ? {RESULT_W{1'b1}} : shifted[RESULT_W-1:0];
    end else begin : g_nosat
      assign clipped = RESULT_W'(shifted);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= emit_i;
      if (emit_i) result_o <= clipped;
    end
  end
endmodule

// File: rtl/adc_ad_status.sv
module adc_ad_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  input  logic ack_i,
  output logic pending_o,
  output logic overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      pending_o <= emit_i || (pending_o && !ack_i);
      overrun_o <= !ack_i && (overrun_o || (emit_i && pending_o));
    end
  end
endmodule

// File: rtl/adc_accum_decim.sv
module adc_accum_decim #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned RESULT_W = 16,
  parameter int unsigned MAX_LOG2 = 10,
  parameter int unsigned CSEL_W   = 4,
  parameter int unsigned SH_W     = 3,
  localparam int unsigned ACC_W   = SAMPLE_W + MAX_LOG2,
  localparam int unsigned L2_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [2:0]          mode_i,
  input  logic [CSEL_W-1:0]   count_sel_i,
  input  logic [SH_W-1:0]     shift_sel_i,
  input  logic                flush_i,
  input  logic                read_ack_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                result_ready_o,
  output logic                pending_o,
  output logic                overrun_o
);
  logic [L2_W-1:0]  log2_n;
  logic [SH_W-1:0]  shift;
  logic             emit;
  logic [ACC_W-1:0] sum;

  adc_ad_cfg #(
    .SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2), .CSEL_W(CSEL_W), .SH_W(SH_W)
  ) u_cfg (
    .mode_i(mode_i), .count_sel_i(count_sel_i), .shift_sel_i(shift_sel_i),
    .log2_n_o(log2_n), .shift_o(shift)
  );

  adc_ad_accum #(
    .SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i), .sample_i(sample_i),
    .flush_i(flush_i), .log2_n_i(log2_n), .emit_o(emit), .sum_o(sum)
  );

  adc_ad_scale #(
    .ACC_W(ACC_W), .RESULT_W(RESULT_W), .SH_W(SH_W)
  ) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .emit_i(emit), .sum_i(sum), .shift_i(shift),
    .result_o(result_o), .ready_o(result_ready_o)
  );

  adc_ad_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .emit_i(emit), .ack_i(read_ack_i),
    .pending_o(pending_o), .overrun_o(overrun_o)
  );
endmodule

// File: rtl/adc_accum_decim_chk.sv
module adc_accum_decim_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned RESULT_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_valid_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic [2:0]          mode_i,
  input logic                flush_i,
  input logic                read_ack_i,
  input logic [RESULT_W-1:0] result_o,
  input logic                result_ready_o,
  input logic                pending_o,
  input logic                overrun_o
);
  assert_raw12_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_ready_o && $past(mode_i) == 3'd0) |-> result_o == RESULT_W'($past(sample_i)));

  assert_raw10_trunc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_ready_o && $past(mode_i) == 3'd1) |-> result_o == RESULT_W'($past(sample_i) >> 2));

  assert_ready_needs_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_valid_i) |-> !result_ready_o);

  assert_flush_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !result_ready_o);

  assert_ready_sets_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_ready_o |-> pending_o);

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_ack_i && !sample_valid_i) |=> (!pending_o && !overrun_o));

  assert_overrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (result_ready_o && $past(pending_o)));
endmodule

bind adc_accum_decim adc_accum_decim_chk #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W)) chk_i (.*);

// File: tb/adc_accum_decim_test.sv
module adc_accum_decim_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [2:0]  mode_i = '0;
  logic [3:0]  count_sel_i = '0;
  logic [2:0]  shift_sel_i = '0;
  logic        flush_i = 1'b0;
  logic        read_ack_i = 1'b0;
  logic [15:0] result_o;
  logic        result_ready_o;
  logic        pending_o;
  logic        overrun_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  adc_accum_decim uut (.*);

  // {mode 3, count_sel 4, shift_sel 3, sample 12, nsamples 11, expected 16}
  localparam int NV = 14;
  localparam logic [48:0] VECS [NV] = '{
    {3'd0, 4'd0,  3'd0, 12'hABC, 11'd1,    16'h0ABC},
    {3'd1, 4'd0,  3'd0, 12'hABC, 11'd1,    16'h02AF},
    {3'd2, 4'd0,  3'd0, 12'hABC, 11'd1,    16'h00AB},
    {3'd3, 4'd2,  3'd2, 12'h123, 11'd4,    16'h0123},
    {3'd3, 4'd3,  3'd0, 12'h100, 11'd8,    16'h0800},
    {3'd3, 4'd0,  3'd7, 12'hFFF, 11'd1,    16'h001F},
    {3'd3, 4'd10, 3'd0, 12'hFFF, 11'd1024, 16'hFFFF},
    {3'd3, 4'd5,  3'd0, 12'hFFF, 11'd32,   16'hFFFF},
    {3'd3, 4'd4,  3'd0, 12'hFFF, 11'd16,   16'hFFF0},
    {3'd4, 4'd9,  3'd7, 12'h800, 11'd4,    16'h1000},
    {3'd5, 4'd0,  3'd0, 12'hFFF, 11'd16,   16'h3FFC},
    {3'd6, 4'd1,  3'd5, 12'h001, 11'd64,   16'h0008},
    {3'd7, 4'd0,  3'd0, 12'hFFF, 11'd256,  16'hFFF0},
    {3'd3, 4'd15, 3'd4, 12'h010, 11'd1024, 16'h0400}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m, input logic [15:0] e);
    if (m == 3'd0) return "R1";
    if (m <= 3'd2) return "R2";
    if (m == 3'd3) return (e == 16'hFFFF) ? "R4" : "R3";
    return "R5";
  endfunction

  // drive n copies of s; return number of ready pulses and last result
  task automatic feed(input logic [11:0] s, input int n, output int pulses, output logic [15:0] res);
    pulses = 0;
    res = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (result_ready_o) pulses++;
      sample_valid_i = 1'b1;
      sample_i = s;
    end
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    if (result_ready_o) begin
      pulses++;
      res = result_o;
    end
  endtask

  task automatic ack();
    @(negedge clk_i);
    read_ack_i = 1'b1;
    @(negedge clk_i);
    read_ack_i = 1'b0;
  endtask

  initial begin
    int p;
    logic [15:0] r;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", "result", 32'(result_o), 32'h0);
    check("R10", "ready", 32'(result_ready_o), 32'h0);
    check("R10", "pending", 32'(pending_o), 32'h0);
    check("R10", "overrun", 32'(overrun_o), 32'h0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      e = VECS[v];
      mode_i      = e[48:46];
      count_sel_i = e[45:42];
      shift_sel_i = e[41:39];
      feed(e[38:27], int'(e[26:16]), p, r);
      check(req_of(e[48:46], e[15:0]), "result", 32'(r), 32'(e[15:0]));
      check("R6", "pulses per window", p, 1);
      @(negedge clk_i);
      check("R6", "strobe ends", 32'(result_ready_o), 32'h0);
      check("R6", "result held", 32'(result_o), 32'(e[15:0]));
      ack();
      check("R8", "ack clears pending", 32'(pending_o), 32'h0);
    end

    // R7: flush drops partial window and the sample beside it
    mode_i = 3'd3; count_sel_i = 4'd2; shift_sel_i = 3'd0;
    feed(12'h100, 3, p, r);
    @(negedge clk_i);
    flush_i = 1'b1; sample_valid_i = 1'b1; sample_i = 12'hFFF;
    @(negedge clk_i);
    flush_i = 1'b0; sample_valid_i = 1'b0;
    check("R7", "no result on flush", 32'(result_ready_o), 32'h0);
    feed(12'h001, 4, p, r);
    check("R7", "sum after flush", 32'(r), 32'h4);
    check("R7", "pulses", p, 1);
    ack();

    // R8: ack with a new result keeps pending, no overrun
    mode_i = 3'd0;
    feed(12'h011, 1, p, r);
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_i = 12'h022; read_ack_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0; read_ack_i = 1'b0;
    check("R8", "pending kept", 32'(pending_o), 32'h1);
    check("R9", "no overrun on acked replace", 32'(overrun_o), 32'h0);
    check("R1", "second result", 32'(result_o), 32'h022);

    // R9: unacknowledged replacement
    feed(12'h033, 1, p, r);
    check("R9", "overrun set", 32'(overrun_o), 32'h1);
    repeat (3) @(negedge clk_i);
    check("R9", "overrun sticky", 32'(overrun_o), 32'h1);
    ack();
    check("R9", "overrun cleared", 32'(overrun_o), 32'h0);
    check("R8", "pending cleared", 32'(pending_o), 32'h0);

    // R2: 8-bit back-to-back, R6 strobe per sample
    mode_i = 3'd2;
    feed(12'hF0F, 2, p, r);
    check("R2", "8-bit result", 32'(r), 32'hF0);
    check("R6", "one pulse per native sample", p, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule